// File: doc/BRIEF.md
# Byte-Serial MAC Port Adapter

This block sits between a narrow pin interface and a multiply-accumulate core. Operands arrive one byte at a time on an 8-bit input, qualified by a byte-valid strobe. A small position counter steers each accepted byte into a staging slot. When the last byte of a four-byte group is accepted, both 16-bit operands are presented to the core together, and a single-cycle compute pulse is raised.

On the output side, the 32-bit accumulator value is split into halves and shown on two byte-wide buses. An external phase input chooses which half is shown. The output selection is registered, so the pins change only on a clock edge, one cycle after the phase and accumulator are sampled.

The arithmetic itself is outside this block. The adapter only orders bytes, aligns the hand-off to the core and selects the result half.

Top module: `bsmac_byte_io`

## Requirements
- R1: While the active-low reset is low, and after it is released, the sequence position is 0. The operand outputs are 0, the compute pulse is low, and both output buses are 0. A reset in the middle of a group discards the bytes already accepted.
- R2: Within a group, the accepted bytes map as follows. Byte 0 goes to operand A bits 7:0 and byte 1 to A bits 15:8. Byte 2 goes to operand B bits 7:0 and byte 3 to B bits 15:8.
- R3: The compute pulse is high for exactly one clock cycle. It appears in the cycle right after the clock edge that accepts the fourth byte of a group, and at no other time.
- R4: Operand A and operand B change only in the cycle where the compute pulse is high. They keep their values through partial groups and idle cycles.
- R5: After the fourth byte, the position wraps, so the next accepted byte is byte 0 of a new group.
- R6: A cycle with byte-valid low is ignored. The data on the input bus is not captured, and the sequence position does not move.
- R7: With phase input 0, the first output bus shows accumulator bits 7:0 and the second shows bits 15:8.
- R8: With phase input 1, the first output bus shows accumulator bits 23:16 and the second shows bits 31:24.
- R9: The output buses are registered. They show the accumulator and phase values sampled at the previous clock edge, and they do not change between edges.
- R10: Bytes sent on consecutive cycles with no gaps produce one compute pulse every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_byte | input | 8 | Serial operand byte |
| in_valid | input | 1 | Byte-valid strobe |
| phase_sel | input | 1 | Result half select (0 = low half, 1 = high half) |
| op_a | output | 16 | Assembled operand A for the core |
| op_b | output | 16 | Assembled operand B for the core |
| go | output | 1 | One-cycle compute pulse |
| acc_in | input | 32 | Accumulator value from the core |
| out_lo | output | 8 | First output bus |
| out_hi | output | 8 | Second output bus |

## Verification
The bench interleaves invalid cycles that carry junk data inside a group. A design that captured data without the strobe, or advanced the position anyway, would assemble wrong operands or pulse too early. It also pulls reset halfway through a group and then sends a full group. A counter that survived the reset would misalign every later byte.

Groups are also sent back to back. This catches a compute pulse that lasts more than one cycle, a missing wrap, or operands that change between pulses.

On the output side, the bench changes the phase and the accumulator and looks at the buses before the next edge and after it. A combinational multiplexer would update early. Swapped halves or swapped buses would show the wrong bytes.

// File: rtl/bsio_pkg.sv
package bsio_pkg;
  localparam int unsigned BSIO_BYTE_W     = 8;
  localparam int unsigned BSIO_OP_BYTES   = 2;
  localparam int unsigned BSIO_RES_PHASES = 2;

  typedef enum logic [0:0] {
    PH_LOWER = 1'b0,
    PH_UPPER = 1'b1
  } res_phase_e;
endpackage

// File: rtl/bsio_byte_seq.sv
module bsio_byte_seq #(
  parameter int unsigned SEQ_LEN = 4,
  localparam int unsigned CNT_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic [CNT_W-1:0] pos,
  output logic             last_byte
);
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_d;
  logic             at_end;

  assign at_end = (pos_q == CNT_W'(SEQ_LEN - 1));

  always_comb begin
    pos_d = pos_q;
    if (in_valid) begin
      if (at_end) pos_d = '0;
      else        pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos       = pos_q;
  assign last_byte = in_valid && at_end;
endmodule

// File: rtl/bsio_operand_regs.sv
module bsio_operand_regs #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned OP_BYTES = 2,
  localparam int unsigned OP_W    = BYTE_W * OP_BYTES,
  localparam int unsigned SEQ_LEN = 2 * OP_BYTES,
  localparam int unsigned CNT_W   = $clog2(SEQ_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic [CNT_W-1:0]  pos,
  input  logic              last_byte,
  output logic [OP_W-1:0]   op_a,
  output logic [OP_W-1:0]   op_b,
  output logic              go
);
  logic [BYTE_W-1:0] stage_q [0:SEQ_LEN-2];
  logic [OP_W-1:0]   a_asm;
  logic [OP_W-1:0]   b_asm;
  logic [OP_W-1:0]   a_q, b_q;
  logic [OP_W-1:0]   a_d, b_d;
  logic              go_q, go_d;

  for (genvar i = 0; i < SEQ_LEN - 1; i++) begin : g_stage
    logic              stage_en;
    logic [BYTE_W-1:0] stage_d;
    assign stage_en = in_valid && (pos == CNT_W'(i));
    always_comb begin
      stage_d = stage_q[i];
      if (stage_en) stage_d = in_byte;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_d;
    end
  end

  for (genvar j = 0; j < OP_BYTES; j++) begin : g_asm_a
    assign a_asm[j*BYTE_W +: BYTE_W] = stage_q[j];
  end
  for (genvar j = 0; j < OP_BYTES - 1; j++) begin : g_asm_b
    assign b_asm[j*BYTE_W +: BYTE_W] = stage_q[OP_BYTES + j];
  end
  assign b_asm[OP_W-1 -: BYTE_W] = in_byte;

  always_comb begin
    a_d  = a_q;
    b_d  = b_q;
    go_d = last_byte;
    if (last_byte) begin
      a_d = a_asm;
      b_d = b_asm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      go_q <= 1'b0;
    end else begin
      a_q  <= a_d;
      b_q  <= b_d;
      go_q <= go_d;
    end
  end

  assign op_a = a_q;
  assign op_b = b_q;
  assign go   = go_q;
endmodule

// File: rtl/bsio_result_mux.sv
module bsio_result_mux #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned RES_PHASES = 2,
  localparam int unsigned RES_W     = 2 * BYTE_W * RES_PHASES,
  localparam int unsigned PH_W      = (RES_PHASES > 1) ? $clog2(RES_PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   phase_sel,
  input  logic [RES_W-1:0]  acc_in,
  output logic [BYTE_W-1:0] out_lo,
  output logic [BYTE_W-1:0] out_hi
);
  logic [BYTE_W-1:0] lo_d, hi_d;
  logic [BYTE_W-1:0] lo_q, hi_q;

  always_comb begin
    lo_d = '0;
    hi_d = '0;
    for (int p = 0; p < RES_PHASES; p++) begin
      if (phase_sel == PH_W'(p)) begin
        lo_d = acc_in[p*2*BYTE_W +: BYTE_W];
        hi_d = acc_in[p*2*BYTE_W + BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign out_lo = lo_q;
  assign out_hi = hi_q;
endmodule

// File: rtl/bsmac_byte_io.sv
module bsmac_byte_io
  import bsio_pkg::*;
#(
  parameter int unsigned BYTE_W     = BSIO_BYTE_W,
  parameter int unsigned OP_BYTES   = BSIO_OP_BYTES,
  parameter int unsigned RES_PHASES = BSIO_RES_PHASES,
  localparam int unsigned OP_W      = BYTE_W * OP_BYTES,
  localparam int unsigned SEQ_LEN   = 2 * OP_BYTES,
  localparam int unsigned CNT_W     = $clog2(SEQ_LEN),
  localparam int unsigned RES_W     = 2 * BYTE_W * RES_PHASES,
  localparam int unsigned PH_W      = (RES_PHASES > 1) ? $clog2(RES_PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic [PH_W-1:0]   phase_sel,
  output logic [OP_W-1:0]   op_a,
  output logic [OP_W-1:0]   op_b,
  output logic              go,
  input  logic [RES_W-1:0]  acc_in,
  output logic [BYTE_W-1:0] out_lo,
  output logic [BYTE_W-1:0] out_hi
);
  logic [CNT_W-1:0] seq_pos;
  logic             seq_last;

  bsio_byte_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pos       (seq_pos),
    .last_byte (seq_last)
  );

  bsio_operand_regs #(.BYTE_W(BYTE_W), .OP_BYTES(OP_BYTES)) u_ops (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_byte   (in_byte),
    .in_valid  (in_valid),
    .pos       (seq_pos),
    .last_byte (seq_last),
    .op_a      (op_a),
    .op_b      (op_b),
    .go        (go)
  );

  bsio_result_mux #(.BYTE_W(BYTE_W), .RES_PHASES(RES_PHASES)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_sel (phase_sel),
    .acc_in    (acc_in),
    .out_lo    (out_lo),
    .out_hi    (out_hi)
  );
endmodule

// File: rtl/bsio_chk.sv
module bsio_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned OP_W   = 16,
  parameter int unsigned RES_W  = 32,
  parameter int unsigned PH_W   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BYTE_W-1:0] in_byte,
  input logic              in_valid,
  input logic [PH_W-1:0]   phase_sel,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic              go,
  input logic [RES_W-1:0]  acc_in,
  input logic [BYTE_W-1:0] out_lo,
  input logic [BYTE_W-1:0] out_hi
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go); // R3

  AST_GO_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && go) |-> $past(in_valid)); // R3

  AST_OPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !go) |-> ($stable(op_a) && $stable(op_b))); // R4

  AST_B_TOP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && go) |-> (op_b[OP_W-1 -: BYTE_W] == $past(in_byte))); // R2

  AST_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ($past(phase_sel) == '0)) |->
      (out_lo == $past(acc_in[BYTE_W-1:0]) &&
       out_hi == $past(acc_in[2*BYTE_W-1:BYTE_W]))); // R7

  AST_PHASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ($past(phase_sel) == PH_W'(1))) |->
      (out_lo == $past(acc_in[3*BYTE_W-1:2*BYTE_W]) &&
       out_hi == $past(acc_in[4*BYTE_W-1:3*BYTE_W]))); // R8
endmodule

bind bsmac_byte_io bsio_chk #(
  .BYTE_W (BYTE_W),
  .OP_W   (OP_W),
  .RES_W  (RES_W),
  .PH_W   (PH_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_byte   (in_byte),
  .in_valid  (in_valid),
  .phase_sel (phase_sel),
  .op_a      (op_a),
  .op_b      (op_b),
  .go        (go),
  .acc_in    (acc_in),
  .out_lo    (out_lo),
  .out_hi    (out_hi)
);

// File: tb/bsmac_byte_io_tb.sv
module bsmac_byte_io_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  in_byte;
  logic        in_valid;
  logic [0:0]  phase_sel;
  logic [15:0] op_a, op_b;
  logic        go;
  logic [31:0] acc_in;
  logic [7:0]  out_lo, out_hi;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  logic [15:0] last_a = '0;
  logic [15:0] last_b = '0;
  logic        prev_go = 1'b0;
  int          cyc = 0;
  int          go_cyc = 0;
  int          prev_go_cyc = 0;

  always #4 clk = ~clk;

  bsmac_byte_io u_dut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .phase_sel(phase_sel), .op_a(op_a), .op_b(op_b), .go(go),
    .acc_in(acc_in), .out_lo(out_lo), .out_hi(out_hi)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic v);
    @(negedge clk);
    in_byte  = b;
    in_valid = v;
  endtask

  // driver: pushes the expected operand pair, then streams the group
  task automatic send_group(input logic [15:0] a, input logic [15:0] b,
                            input int gap);
    logic [7:0] bytes [4];
    bytes[0] = a[7:0];  bytes[1] = a[15:8];
    bytes[2] = b[7:0];  bytes[3] = b[15:8];
    exp_q.push_back({a, b});
    for (int k = 0; k < 4; k++) begin
      for (int g = 0; g < gap; g++) send_byte(8'hE7 ^ 8'(g + k), 1'b0); // R6 junk
      send_byte(bytes[k], 1'b1);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) send_byte(8'h5A, 1'b0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      last_a  = '0;
      last_b  = '0;
      prev_go = 1'b0;
    end else begin
      cyc++;
      if (go) begin
        chk(!prev_go, "R3 pulse width", 32'(prev_go), 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected pulse", 32'd1, 32'd0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({op_a, op_b} == e, "R2 operand assembly", {op_a, op_b}, e);
        end
        last_a      = op_a;
        last_b      = op_b;
        prev_go_cyc = go_cyc;
        go_cyc      = cyc;
      end else begin
        chk(op_a == last_a && op_b == last_b, "R4 operands hold",
            {op_a, op_b}, {last_a, last_b});
      end
      prev_go = go;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_byte = '0; in_valid = 1'b0; phase_sel = 1'b0; acc_in = '0;
    repeat (3) @(negedge clk);
    chk(go == 1'b0 && op_a == '0 && op_b == '0, "R1 reset ops", {op_a, op_b}, 32'd0);
    chk(out_lo == '0 && out_hi == '0, "R1 reset outputs", {out_hi, out_lo}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R2, R3: contiguous group
    send_group(16'h3C81, 16'h7F02, 0);
    idle(3);
    // R6: invalid junk between bytes, R4 checked by monitor
    send_group(16'hA55A, 16'h0FF0, 2);
    idle(3);
    // R5, R10: back-to-back groups with no gaps
    send_group(16'h1234, 16'h5678, 0);
    send_group(16'h9ABC, 16'hDEF0, 0);
    idle(3);
    chk(go_cyc - prev_go_cyc == 4, "R10 pulse spacing",
        32'(go_cyc - prev_go_cyc), 32'd4);

    // R1: reset mid-group discards partial bytes
    send_byte(8'h11, 1'b1);
    send_byte(8'h22, 1'b1);
    @(negedge clk) begin in_valid = 1'b0; rst_n = 1'b0; end
    @(negedge clk);
    chk(op_a == '0 && op_b == '0 && go == 1'b0, "R1 mid reset",
        {op_a, op_b}, 32'd0);
    rst_n = 1'b1;
    idle(1);
    send_group(16'hC0DE, 16'hBEEF, 0);  // R5 realigned from byte 0
    idle(3);
    chk(exp_q.size() == 0, "R3 all pulses seen", 32'(exp_q.size()), 32'd0);

    // R7: low half
    @(negedge clk) begin acc_in = 32'hA1B2C3D4; phase_sel = 1'b0; end
    @(negedge clk);
    chk(out_lo == 8'hD4 && out_hi == 8'hC3, "R7 phase 0",
        {out_hi, out_lo}, 32'hC3D4);
    // R9: no change before the edge
    acc_in = 32'h11223344; phase_sel = 1'b1;
    #1;
    chk(out_lo == 8'hD4 && out_hi == 8'hC3, "R9 registered",
        {out_hi, out_lo}, 32'hC3D4);
    // R8: high half after the edge
    @(negedge clk);
    chk(out_lo == 8'h22 && out_hi == 8'h11, "R8 phase 1",
        {out_hi, out_lo}, 32'h1122);
    acc_in = 32'h8899AABB; phase_sel = 1'b0;
    @(negedge clk);
    chk(out_lo == 8'hBB && out_hi == 8'hAA, "R7 phase 0 again",
        {out_hi, out_lo}, 32'hAABB);
    idle(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule